// File: doc/BRIEF.md
# Parallel I/O Port Controller

A 32-pin general-purpose I/O bank driven from a simple word-addressed register bus. Each pin has eight attributes: ownership of the pad, output enable, input glitch filter, output data, open-drain drive, pull-up, output-write mask and interrupt mask. Every attribute sits in its own status register. Software never writes a status register directly. Instead, writing ones to the attribute's "set" address turns bits on, and writing ones to its "clear" address turns them off. Zero bits in either write leave the matching pins alone. The one exception is the output data register, which can also be written directly through its status address, but only on pins whose output-write mask bit is 1.

On the pad side, the block merges its own drive with a peripheral's drive. It chooses per pin between them according to the ownership bit, and supports push-pull and open-drain drive. Pin inputs pass through a two-stage synchronizer and an optional glitch filter into a level register that software can read. Any change of that level latches an event bit. The interrupt output is the OR of the event bits gated by the interrupt mask. Reading the event register clears it.

The bus and pin ports are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A bus write is taken on every clock edge where `bus_wr` is high. A read returns `bus_rdata` combinationally in the cycle where `bus_rd` is high.

Top module: `pio_bank`

## Requirements
- R1: After reset every status register, the level register and the event register read 0. Every pad is therefore owned by the peripheral, and `irq` is 0.
- R2: Each attribute k (own=0, dir=1, filter=2, data=3, open-drain=4, pull-up=5, write-mask=6, irq-mask=7) has a set address 3k, a clear address 3k+1 and a status address 3k+2. A write to the set address ORs `bus_wdata` into the status. A write to the clear address removes the `bus_wdata` bits from the status. Zero bits change nothing, and the status address reads back the register.
- R3: A pin whose ownership bit is 0 passes `per_out` and `per_oe` to `pad_out` and `pad_oe`.
- R4: An owned pin that is not open-drain drives `pad_out` from its data bit and `pad_oe` from its direction bit.
- R5: An owned, open-drain pin has `pad_out` 0. Its `pad_oe` is high only when the direction bit is 1 and the data bit is 0, so the pin is released when the data bit is 1.
- R6: A write to the data status address (11) changes only the data bits whose write-mask bit is 1. All other data bits keep their value.
- R7: With the filter off, a pin change appears in the level register (address 25) after exactly three rising clock edges.
- R8: With the filter on, an input level is accepted only after two consecutive synchronized samples agree. This adds one edge of delay (four in total), and a pulse one clock sample wide never reaches the level register.
- R9: Any change of the level register sets that pin's bit in the event register (address 24). A read of address 24 clears the register, but a change on the same edge still sets its bit.
- R10: `irq` is high exactly when some event bit and the matching interrupt-mask bit are both 1.
- R11: `pad_pu` presents the pull-up status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears events when reading address 24) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pad input levels |
| per_out | input | 32 | Peripheral output values |
| per_oe | input | 32 | Peripheral output enables |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pull-up enables |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_wr` targets a single address per cycle, so set, clear and direct writes to one register never coincide. They also assume that reset is held across at least one clock edge, so every `$past` value used after release is a reset value. The filter and event properties do not assume any particular timing of `pin_in`, because it is sampled through the synchronizer. Even so, the bench changes pins and bus signals only on falling edges, one access at a time, so each expected latency can be counted in whole rising edges.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NUM_ATTR = 8;
  localparam int ATT_OWN  = 0;
  localparam int ATT_DIR  = 1;
  localparam int ATT_FLT  = 2;
  localparam int ATT_DAT  = 3;
  localparam int ATT_OD   = 4;
  localparam int ATT_PU   = 5;
  localparam int ATT_WM   = 6;
  localparam int ATT_IM   = 7;
  localparam int ADR_EVT  = 3 * NUM_ATTR;
  localparam int ADR_LVL  = 3 * NUM_ATTR + 1;
endpackage

// File: rtl/pio_attr.sv
module pio_attr #(
  parameter int W = 32,
  parameter bit HAS_DIRECT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] direct_val;

  generate
    if (HAS_DIRECT) begin : g_direct
      assign direct_val = (stat & ~mask) | (wdata & mask);
    end else begin : g_plain
      assign direct_val = stat;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat <= '0;
    else if (set_we) stat <= stat | wdata;
    else if (clr_we) stat <= stat & ~wdata;
    else if (dir_we) stat <= direct_val;
  end

  // R2: bits written to the set address are present afterwards
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((stat & $past(wdata)) == $past(wdata)));
  // R2: bits written to the clear address are gone afterwards
  a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((stat & $past(wdata)) == '0));
  // R6: a direct write leaves unmasked bits untouched
  a_r6_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && !set_we && !clr_we) |=> (((stat ^ $past(stat)) & ~$past(mask)) == '0));
endmodule

// File: rtl/pio_infilter.sv
module pio_infilter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] flt_en,
  input  logic         evt_clr,
  output logic [W-1:0] level,
  output logic [W-1:0] evt
);
  logic [W-1:0] s1_q, s2_q, prev_q, lvl_nxt, chg;

  assign lvl_nxt = (~flt_en & s2_q)
                 | ( flt_en & ~(s2_q ^ prev_q) & s2_q)
                 | ( flt_en &  (s2_q ^ prev_q) & level);
  assign chg = lvl_nxt ^ level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      level  <= '0;
      evt    <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      level  <= lvl_nxt;
      evt    <= (evt_clr ? '0 : evt) | chg;
    end
  end

  // R8: a filtered pin only moves when the two prior samples agreed
  a_r8_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
    ((level ^ $past(level)) & $past(flt_en) & ($past(s2_q) ^ $past(prev_q))) == '0);
  // R9: every level change is recorded as an event
  a_r9_change_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ((level ^ $past(level)) & ~evt) == '0);
endmodule

// File: rtl/pio_padmux.sv
module pio_padmux #(
  parameter int W = 32
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dat,
  input  logic [W-1:0] od,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] per_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drv_out, drv_oe;
    assign drv_out   = od[i] ? 1'b0 : dat[i];
    assign drv_oe    = dir[i] & ~(od[i] & dat[i]);
    assign pad_out[i] = own[i] ? drv_out : per_out[i];
    assign pad_oe[i]  = own[i] ? drv_oe  : per_oe[i];
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  per_out,
  input  logic [W-1:0]  per_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  output logic          irq
);
  import pio_pkg::*;

  logic [W-1:0] stat [NUM_ATTR];
  logic [W-1:0] level, evt;
  logic         evt_clr;

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
    logic set_we, clr_we, dir_we;
    assign set_we = bus_wr && (bus_addr == AW'(3 * g));
    assign clr_we = bus_wr && (bus_addr == AW'(3 * g + 1));
    assign dir_we = bus_wr && (bus_addr == AW'(3 * g + 2));
    pio_attr #(.W(W), .HAS_DIRECT(g == ATT_DAT)) u_attr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .dir_we (dir_we),
      .wdata  (bus_wdata),
      .mask   (stat[ATT_WM]),
      .stat   (stat[g])
    );
  end

  assign evt_clr = bus_rd && (bus_addr == AW'(ADR_EVT));

  pio_infilter #(.W(W)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .flt_en  (stat[ATT_FLT]),
    .evt_clr (evt_clr),
    .level   (level),
    .evt     (evt)
  );

  pio_padmux #(.W(W)) u_pad (
    .own     (stat[ATT_OWN]),
    .dir     (stat[ATT_DIR]),
    .dat     (stat[ATT_DAT]),
    .od      (stat[ATT_OD]),
    .per_out (per_out),
    .per_oe  (per_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign pad_pu = stat[ATT_PU];
  assign irq    = |(evt & stat[ATT_IM]);

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_ATTR; k++) begin
      if (bus_addr == AW'(3 * k + 2)) bus_rdata = stat[k];
    end
    if (bus_addr == AW'(ADR_EVT)) bus_rdata = evt;
    if (bus_addr == AW'(ADR_LVL)) bus_rdata = level;
  end

  // R9: an event read with no new change leaves the event register empty
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> ((evt & ~(level ^ $past(level))) == '0));
endmodule

// File: tb/pio_bank_test.sv
module pio_bank_test;
  localparam int CLK_P = 10;
  localparam int NV = 27;
  // {is_write, addr, data, expected}
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'd0,  32'h0000_00FF, 32'h0},
    {1'b0, 5'd2,  32'h0,         32'h0000_00FF},
    {1'b1, 5'd1,  32'h0000_000F, 32'h0},
    {1'b0, 5'd2,  32'h0,         32'h0000_00F0},
    {1'b1, 5'd3,  32'hF0F0_0000, 32'h0},
    {1'b0, 5'd5,  32'h0,         32'hF0F0_0000},
    {1'b1, 5'd4,  32'h00F0_0000, 32'h0},
    {1'b0, 5'd5,  32'h0,         32'hF000_0000},
    {1'b1, 5'd11, 32'h1234_5678, 32'h0},
    {1'b0, 5'd11, 32'h0,         32'h0},
    {1'b1, 5'd18, 32'h0000_FFFF, 32'h0},
    {1'b0, 5'd20, 32'h0,         32'h0000_FFFF},
    {1'b1, 5'd11, 32'h1234_5678, 32'h0},
    {1'b0, 5'd11, 32'h0,         32'h0000_5678},
    {1'b1, 5'd9,  32'h8000_0000, 32'h0},
    {1'b0, 5'd11, 32'h0,         32'h8000_5678},
    {1'b1, 5'd10, 32'h0000_0008, 32'h0},
    {1'b0, 5'd11, 32'h0,         32'h8000_5670},
    {1'b1, 5'd19, 32'h0000_00FF, 32'h0},
    {1'b1, 5'd11, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 5'd11, 32'h0,         32'h8000_FF70},
    {1'b1, 5'd6,  32'h0000_0100, 32'h0},
    {1'b1, 5'd7,  32'h0000_0000, 32'h0},
    {1'b0, 5'd8,  32'h0,         32'h0000_0100},
    {1'b1, 5'd21, 32'h0000_0010, 32'h0},
    {1'b1, 5'd22, 32'h0000_0010, 32'h0},
    {1'b0, 5'd23, 32'h0,         32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] per_out = 32'hAAAA_AAAA, per_oe = 32'h5555_5555;
  logic [31:0] pad_out, pad_oe, pad_pu;
  logic        irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  pio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .per_out(per_out), .per_oe(per_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1: reset state
    rd(5'd2, v);  check("R1 own", v, 32'h0);
    rd(5'd11, v); check("R1 data", v, 32'h0);
    rd(5'd24, v); check("R1 evt", v, 32'h0);
    check("R1 pad_out", pad_out, per_out);
    check("R1 pad_oe", pad_oe, per_oe);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R6: register vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][68:64], v);
        check(VEC[i][68:64] == 5'd11 ? "R6 data" : "R2 status", v, VEC[i][31:0]);
      end
    end

    do_reset();
    wr(5'd0, 32'h0000_00FF);
    wr(5'd3, 32'h0000_000F);
    wr(5'd9, 32'h0000_0005);
    #1;
    check("R3 R4 pad_out", pad_out, 32'hAAAA_AA05);
    check("R3 R4 pad_oe", pad_oe, 32'h5555_550F);
    wr(5'd12, 32'h0000_0003);
    #1;
    check("R5 pad_out", pad_out, 32'hAAAA_AA04);
    check("R5 pad_oe", pad_oe, 32'h5555_550E);
    wr(5'd15, 32'h8000_0001);
    #1;
    check("R11 pad_pu", pad_pu, 32'h8000_0001);

    // R7: unfiltered latency of three edges
    pin_in[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(5'd25, v); check("R7 level early", v, 32'h0);
    rd(5'd25, v); check("R7 level", v, 32'h0000_0010);
    // R9 / R10
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(5'd21, 32'h0000_0010);
    #1 check("R10 irq", {31'b0, irq}, 32'h1);
    rd(5'd24, v); check("R9 evt", v, 32'h0000_0010);
    rd(5'd24, v); check("R9 evt cleared", v, 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);

    // R8: one-sample pulse on filtered pin 8 and unfiltered pin 9
    wr(5'd6, 32'h0000_0100);
    pin_in[9:8] = 2'b11;
    @(negedge clk);
    pin_in[9:8] = 2'b00;
    repeat (6) @(negedge clk);
    rd(5'd25, v); check("R8 pulse level", v, 32'h0000_0010);
    rd(5'd24, v); check("R8 pulse evt", v, 32'h0000_0200);
    // R8: held level on the filtered pin takes four edges
    pin_in[8] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(5'd25, v); check("R8 level e2", v, 32'h0000_0010);
    rd(5'd25, v); check("R8 level e3", v, 32'h0000_0010);
    rd(5'd25, v); check("R8 level e4", v, 32'h0000_0110);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule